// File: doc/BRIEF.md
# Command-Driven Table Access Engine

This block gives software indirect access to a set of small on-chip lookup tables through a narrow register port. Examples are a VLAN membership table, an untagged-port table and a spanning-tree port-state table. Software first stages one or more 32-bit data words. It then writes a single command word that holds a start flag, a direction flag, a table selector and a row number. The start flag doubles as the busy indication. Hardware keeps it set while the row moves between the staging words and the selected table memory, then clears it. Software polls the command word until the flag drops.

Each table is a synchronous RAM. It has its own depth and its own row width, counted in whole data words. The table set is given by parameter arrays, and a generate loop builds one RAM per table. The engine does not interpret row contents. Field layouts that software chooses are kept bit for bit. Examples are a port bitmap held three places up in word 0, or a 6-bit filtering ID split between the low bits of word 0 and the high bits of word 1.

Top module: `tae_engine`

## Requirements
- R1: After reset the command word, every staging word and any unmapped address all read as zero.
- R2: A register write to address 0 with bit 17 set, made while idle, is accepted. From the next cycle the command word reads back bit 17 = 1 together with the written direction (bit 16), table selector (bits 15:12) and row number (bits 11:0).
- R3: Once accepted, the busy bit (bit 17) reads 1 for exactly three cycles and then clears by itself.
- R4: With bit 16 = 1 the staged words are stored into the addressed row of the table whose type code matches bits 15:12. With bit 16 = 0 that row is copied into the staging words. The default tables have type codes 1, 2 and 4, depths 16, 8 and 32, and widths of 2, 1 and 2 words.
- R5: On a read, the staging words take the row contents one cycle before the busy bit clears, while busy still reads 1.
- R6: After a read, staging words beyond the selected table's row width read 0. On a write, those words are not stored.
- R7: A command word written while busy is ignored. The command readback keeps the running command's fields, and busy clears on the running command's schedule.
- R8: A command whose row number is at or beyond the table depth, or whose type code matches no table, still runs for three busy cycles. It touches no row and leaves the staging words unchanged.
- R9: A write to address 0 with bit 17 clear is ignored.
- R10: Rows are kept bit-exact and separately per table, so the same row number in different tables never aliases.
- R11: Address 0 is the command word, and addresses 1 to MAX_WORDS are staging words 0 onward. Other addresses read 0 and ignore writes. Staging writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |

## Verification
The assertions assume that the register port performs at most one write per cycle. They also assume that software changes no command or staging state while busy, except through writes the block is defined to drop. The stimulus drives every write half a cycle before the capturing edge. It sends deliberately conflicting writes only during busy windows, and only to test that they are dropped. The sweep writes and reads back every row of every default table with arithmetic patterns. Out-of-range rows and an unused type code are used only for their dedicated checks.

// File: rtl/tae_pkg.sv
package tae_pkg;
   localparam int unsigned DATA_W   = 32;
   localparam int unsigned IDX_W    = 12;
   localparam int unsigned TYPE_W   = 4;
   localparam int unsigned EXEC_BIT = 17;
   localparam int unsigned DIR_BIT  = 16;
   localparam int unsigned TYPE_LSB = 12;
   localparam int unsigned CMD_W    = EXEC_BIT + 1;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ACCESS,
      ST_LOAD,
      ST_FIN
   } tae_state_e;
endpackage

// File: rtl/tae_row_ram.sv
module tae_row_ram #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned ROW_W = 64,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             we,
   input  logic [AW-1:0]    addr,
   input  logic [ROW_W-1:0] wdata,
   output logic [ROW_W-1:0] rdata
);
   logic [ROW_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en && we) begin
         mem[addr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (en && !we) begin
         rdata <= mem[addr];
      end
   end
endmodule

// File: rtl/tae_cmd_ctrl.sv
module tae_cmd_ctrl import tae_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_wdata,
   output logic              busy,
   output logic              cmd_dir,
   output logic [TYPE_W-1:0] cmd_type,
   output logic [IDX_W-1:0]  cmd_idx,
   output logic              access_stb,
   output logic              load_stb
);
   tae_state_e state;
   logic       accept;

   assign accept     = cmd_wr && cmd_wdata[EXEC_BIT] && (state == ST_IDLE);
   assign busy       = (state != ST_IDLE);
   assign access_stb = (state == ST_ACCESS);
   assign load_stb   = (state == ST_LOAD) && !cmd_dir;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cmd_dir  <= 1'b0;
         cmd_type <= '0;
         cmd_idx  <= '0;
      end else begin
         unique case (state)
            ST_IDLE:   if (accept) state <= ST_ACCESS;
            ST_ACCESS: state <= ST_LOAD;
            ST_LOAD:   state <= ST_FIN;
            default:   state <= ST_IDLE;
         endcase
         if (accept) begin
            cmd_dir  <= cmd_wdata[DIR_BIT];
            cmd_type <= cmd_wdata[TYPE_LSB +: TYPE_W];
            cmd_idx  <= cmd_wdata[IDX_W-1:0];
         end
      end
   end

   // R3
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(busy, 1) && $past(busy, 2) && $past(busy, 3)));

   // R3
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy ##1 busy);

   // R7
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable({cmd_dir, cmd_type, cmd_idx}));
endmodule

// File: rtl/tae_data_stage.sv
module tae_data_stage import tae_pkg::*; #(
   parameter int unsigned MAX_WORDS = 2,
   localparam int unsigned ROWMAX   = MAX_WORDS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MAX_WORDS-1:0] word_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              load,
   input  logic [ROWMAX-1:0] load_row,
   output logic [ROWMAX-1:0] data_q
);
   for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            data_q[w*DATA_W +: DATA_W] <= '0;
         end else if (load) begin
            data_q[w*DATA_W +: DATA_W] <= load_row[w*DATA_W +: DATA_W];
         end else if (word_we[w]) begin
            data_q[w*DATA_W +: DATA_W] <= wdata;
         end
      end
   end
endmodule

// File: rtl/tae_engine.sv
module tae_engine import tae_pkg::*; #(
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned MAX_WORDS = 2,
   parameter int unsigned NTBL      = 3,
   parameter int unsigned TBL_TYPE  [NTBL] = '{1, 2, 4},
   parameter int unsigned TBL_DEPTH [NTBL] = '{16, 8, 32},
   parameter int unsigned TBL_WORDS [NTBL] = '{2, 1, 2}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);
   localparam int unsigned ROWMAX = MAX_WORDS * DATA_W;

   logic              busy, cmd_dir, access_stb, load_stb;
   logic [TYPE_W-1:0] cmd_type;
   logic [IDX_W-1:0]  cmd_idx;
   logic [ROWMAX-1:0] data_q, load_row;
   logic [ROWMAX-1:0] rd_ext [NTBL];
   logic [NTBL-1:0]   sel, tbl_en;
   logic [MAX_WORDS-1:0] word_we;
   logic              cmd_wr;

   initial begin
      assert ((MAX_WORDS + 1) <= (1 << ADDR_W))
         else $error("address space too small for staging words");
      for (int t = 0; t < NTBL; t++) begin
         assert (TBL_WORDS[t] >= 1 && TBL_WORDS[t] <= MAX_WORDS)
            else $error("table %0d row width out of range", t);
         assert (TBL_DEPTH[t] >= 2 && TBL_DEPTH[t] <= (1 << IDX_W))
            else $error("table %0d depth out of range", t);
         assert (TBL_TYPE[t] < (1 << TYPE_W))
            else $error("table %0d type code too wide", t);
         for (int u = t + 1; u < NTBL; u++) begin
            assert (TBL_TYPE[t] != TBL_TYPE[u])
               else $error("tables %0d and %0d share a type code", t, u);
         end
      end
   end

   assign cmd_wr = reg_we && (reg_addr == '0);

   tae_cmd_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wr     (cmd_wr),
      .cmd_wdata  (reg_wdata[CMD_W-1:0]),
      .busy       (busy),
      .cmd_dir    (cmd_dir),
      .cmd_type   (cmd_type),
      .cmd_idx    (cmd_idx),
      .access_stb (access_stb),
      .load_stb   (load_stb)
   );

   for (genvar w = 0; w < MAX_WORDS; w++) begin : g_wdec
      assign word_we[w] = reg_we && !busy && (int'(reg_addr) == w + 1);
   end

   tae_data_stage #(.MAX_WORDS(MAX_WORDS)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_we  (word_we),
      .wdata    (reg_wdata),
      .load     (load_stb),
      .load_row (load_row),
      .data_q   (data_q)
   );

   for (genvar t = 0; t < NTBL; t++) begin : g_tbl
      localparam int unsigned RW = TBL_WORDS[t] * DATA_W;
      localparam int unsigned AW = $clog2(TBL_DEPTH[t]);
      logic [RW-1:0] rd_row;

      assign sel[t]    = (cmd_type == TYPE_W'(TBL_TYPE[t])) &&
                         (int'(cmd_idx) < int'(TBL_DEPTH[t]));
      assign tbl_en[t] = access_stb && sel[t];

      tae_row_ram #(.DEPTH(TBL_DEPTH[t]), .ROW_W(RW)) u_ram (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (tbl_en[t]),
         .we    (cmd_dir),
         .addr  (cmd_idx[AW-1:0]),
         .wdata (data_q[RW-1:0]),
         .rdata (rd_row)
      );

      if (RW == ROWMAX) begin : g_full
         assign rd_ext[t] = rd_row;
      end else begin : g_pad
         assign rd_ext[t] = {{(ROWMAX - RW){1'b0}}, rd_row};
      end
   end

   always_comb begin
      load_row = data_q;
      for (int t = 0; t < NTBL; t++) begin
         if (sel[t]) load_row = rd_ext[t];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == '0) begin
         reg_rdata[EXEC_BIT]              = busy;
         reg_rdata[DIR_BIT]               = cmd_dir;
         reg_rdata[TYPE_LSB +: TYPE_W]    = cmd_type;
         reg_rdata[IDX_W-1:0]             = cmd_idx;
      end
      for (int w = 0; w < MAX_WORDS; w++) begin
         if (int'(reg_addr) == w + 1) reg_rdata = data_q[w*DATA_W +: DATA_W];
      end
   end

   // R8
   one_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tbl_en));

   // R4
   ram_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|tbl_en) |-> busy);

   // R11
   stage_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(data_q)) |-> !cmd_dir);
endmodule

// File: tb/tb_tae_engine.sv
module tb_tae_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   localparam int NT = 3;
   localparam int T_TYPE  [NT] = '{1, 2, 4};
   localparam int T_DEPTH [NT] = '{16, 8, 32};
   localparam int T_WORDS [NT] = '{2, 1, 2};

   always #5 clk = ~clk;

   tae_engine dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata)
   );

   function automatic logic [31:0] pat(int t, int i, int w);
      return (32'(t + 1) * 32'h0100_0193) ^ (32'(i) * 32'h9E37_79B1) ^
             (32'(w) << 30) ^ 32'h5A5A_0000;
   endfunction

   function automatic logic [31:0] mk(logic dir, int ty, int idx);
      return (32'd1 << 17) | (32'(dir) << 16) | (32'(ty) << 12) | 32'(idx);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      reg_addr = a[1:0];
      #1;
      v = reg_rdata;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      reg_we = 1'b1;
      reg_addr = a[1:0];
      reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic poll(output int n);
      logic [31:0] v;
      n = 0;
      rd(0, v);
      while (v[17] && n < 20) begin
         n++;
         @(negedge clk);
         rd(0, v);
      end
   endtask

   task automatic run_cmd(input logic [31:0] c, output int n);
      wr(0, c);
      poll(n);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%08h expected=%08h", 32'd1, 32'd0);
         summary();
      end
   end

   initial begin
      logic [31:0] v, w0, w1;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(a, v);
         chk(v == 32'd0, "R1", v, 32'd0);
      end

      // R11 register map
      wr(1, 32'h1111_2222);
      wr(2, 32'h3333_4444);
      wr(3, 32'hFFFF_FFFF);
      rd(1, v); chk(v == 32'h1111_2222, "R11", v, 32'h1111_2222);
      rd(2, v); chk(v == 32'h3333_4444, "R11", v, 32'h3333_4444);
      rd(3, v); chk(v == 32'd0, "R11", v, 32'd0);

      // R9 command without start bit
      wr(0, 32'h0001_4005);
      rd(0, v); chk(v == 32'd0, "R9", v, 32'd0);
      @(negedge clk);
      rd(0, v); chk(v == 32'd0, "R9", v, 32'd0);

      // R4 R3 sweep: write every row of every table
      for (int t = 0; t < NT; t++) begin
         for (int i = 0; i < T_DEPTH[t]; i++) begin
            wr(1, pat(t, i, 0));
            wr(2, pat(t, i, 1));
            run_cmd(mk(1'b1, T_TYPE[t], i), n);
            chk(n == 3, "R3", 32'(n), 32'd3);
         end
      end
      // R4 R6 R10 read back every row
      for (int t = 0; t < NT; t++) begin
         for (int i = 0; i < T_DEPTH[t]; i++) begin
            wr(1, 32'hFFFF_FFFF);
            wr(2, 32'hFFFF_FFFF);
            run_cmd(mk(1'b0, T_TYPE[t], i), n);
            for (int w = 0; w < 2; w++) begin
               rd(w + 1, v);
               if (w < T_WORDS[t]) chk(v == pat(t, i, w), "R4 R10", v, pat(t, i, w));
               else chk(v == 32'd0, "R6", v, 32'd0);
            end
         end
      end

      // R2 readback while busy and after completion
      wr(0, mk(1'b0, 4, 12'h01A));
      rd(0, v);
      chk(v == mk(1'b0, 4, 12'h01A), "R2", v, mk(1'b0, 4, 12'h01A));
      poll(n);
      rd(0, v);
      chk(v == 32'h0000_401A, "R2", v, 32'h0000_401A);

      // R5 read load one cycle before busy clears
      wr(1, 32'hA5A5_A5A5);
      wr(2, 32'hC3C3_C3C3);
      wr(0, mk(1'b0, 1, 5));
      rd(1, v); chk(v == 32'hA5A5_A5A5, "R5", v, 32'hA5A5_A5A5);
      @(negedge clk);
      rd(1, v); chk(v == 32'hA5A5_A5A5, "R5", v, 32'hA5A5_A5A5);
      @(negedge clk);
      rd(1, v); chk(v == pat(0, 5, 0), "R5", v, pat(0, 5, 0));
      rd(0, v); chk(v[17] == 1'b1, "R5", v, mk(1'b0, 1, 5));
      @(negedge clk);
      rd(0, v); chk(v[17] == 1'b0, "R5", v, 32'h0000_1005);

      // R7 command while busy is ignored
      wr(0, mk(1'b0, 4, 6));
      wr(0, mk(1'b1, 1, 2));
      rd(0, v); chk(v == mk(1'b0, 4, 6), "R7", v, mk(1'b0, 4, 6));
      poll(n);
      chk(n == 2, "R7", 32'(n), 32'd2);
      run_cmd(mk(1'b0, 1, 2), n);
      rd(1, v); chk(v == pat(0, 2, 0), "R7", v, pat(0, 2, 0));

      // R11 staging write during busy is ignored
      wr(1, 32'h1234_5678);
      wr(2, 32'h9ABC_DEF0);
      wr(0, mk(1'b1, 4, 7));
      wr(1, 32'hDEAD_BEEF);
      poll(n);
      rd(1, v); chk(v == 32'h1234_5678, "R11", v, 32'h1234_5678);
      wr(1, 32'd0);
      run_cmd(mk(1'b0, 4, 7), n);
      rd(1, v); chk(v == 32'h1234_5678, "R11", v, 32'h1234_5678);

      // R8 out-of-range read leaves staging words alone
      wr(1, 32'h0BAD_0BAD);
      run_cmd(mk(1'b0, 2, 8), n);
      chk(n == 3, "R8", 32'(n), 32'd3);
      rd(1, v); chk(v == 32'h0BAD_0BAD, "R8", v, 32'h0BAD_0BAD);
      // R8 out-of-range write must not wrap onto row 0
      wr(1, 32'h7777_7777);
      run_cmd(mk(1'b1, 1, 16), n);
      chk(n == 3, "R8", 32'(n), 32'd3);
      run_cmd(mk(1'b0, 1, 0), n);
      rd(1, v); chk(v == pat(0, 0, 0), "R8", v, pat(0, 0, 0));
      // R8 unknown type code
      wr(1, 32'h0F0F_0F0F);
      run_cmd(mk(1'b0, 7, 0), n);
      chk(n == 3, "R8", 32'(n), 32'd3);
      rd(1, v); chk(v == 32'h0F0F_0F0F, "R8", v, 32'h0F0F_0F0F);

      // R10 membership row with bitmap shifted by 3 and split filtering ID
      begin
         logic [28:0] bmap;
         logic [5:0]  fid;
         bmap = 29'h0ABC_DE1;
         fid  = 6'b101_101;
         w0 = {bmap, fid[5:3]};
         w1 = {fid[2:0], 1'b1, 1'b0, 3'd5, 24'd0};
         wr(1, w0);
         wr(2, w1);
         run_cmd(mk(1'b1, 1, 15), n);
         wr(1, 32'd0);
         wr(2, 32'd0);
         run_cmd(mk(1'b0, 1, 15), n);
         rd(1, v);
         chk(v[31:3] == bmap, "R10", {3'b0, v[31:3]}, {3'b0, bmap});
         rd(2, w1);
         chk({v[2:0], w1[31:29]} == fid, "R10", {26'd0, v[2:0], w1[31:29]}, {26'd0, fid});
         chk(w1[26:24] == 3'd5 && w1[28:27] == 2'b10, "R10", w1, {3'b101, 2'b10, 3'd5, 24'd0});
      end

      // R10 same row number in another table is untouched
      run_cmd(mk(1'b0, 4, 15), n);
      rd(1, v); chk(v == pat(2, 15, 0), "R10", v, pat(2, 15, 0));
      rd(2, v); chk(v == pat(2, 15, 1), "R10", v, pat(2, 15, 1));

      done = 1'b1;
      summary();
   end
endmodule